// File: doc/BRIEF.md
# Banked general-purpose register file

This block is the general-purpose register storage of a small processor core, organised as several complete register banks of which exactly one is active at a time. A task switch in the operating system then costs one write of a bank number into a select register instead of storing and reloading every register. All register reads and writes go to the active bank only. Status, program counter and stack pointer state are held elsewhere and are not banked.

The highest-numbered bank is a smaller bank kept for interrupt service routines and is never selectable as a task bank. An interrupt entry pulse switches the active bank to it. The task selection is preserved underneath and comes back on the interrupt exit pulse. The two read ports are combinational from the active bank. The single write port and the select register update on the rising clock edge.

Top module: `bankrf_top`

## Requirements
- R1: After reset the active bank number is 0, the interrupt flag is low, and every register of every bank reads 0.
- R2: A write on the write port lands at the rising edge and is visible on both read ports from then on. Reads are combinational, so a read of the register being written in the same cycle returns the old value. The two read ports address registers independently.
- R3: A write changes only the addressed register of the active bank. Registers of all other banks keep their values.
- R4: A select write with a task bank number 0..NUM_BANKS-2 makes that bank active from the next clock cycle on, and cur_bank shows it. Until that edge the previous bank remains active.
- R5: A select write with the reserved interrupt bank number (NUM_BANKS-1) or any larger value is ignored, and the current selection is kept.
- R6: An interrupt entry pulse while no interrupt is active makes bank NUM_BANKS-1 active from the next cycle and raises irq_active. A further entry pulse while active has no effect.
- R7: An interrupt exit pulse while active lowers irq_active and restores the task bank that was selected before entry, from the next cycle. An exit pulse while not active has no effect.
- R8: Select writes while the interrupt bank is active are ignored, so the preserved task selection is unchanged at exit.
- R9: While the interrupt bank (IRQ_REGS registers) is active, register numbers IRQ_REGS and above read 0 on both ports. Writes to them are dropped and do not alias onto lower registers.
- R10: Each task bank holds REGS registers of DW bits. All of them are independent storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_addr_a | input | AW | Register number for read port A |
| rd_data_a | output | DW | Read port A data from the active bank |
| rd_addr_b | input | AW | Register number for read port B |
| rd_data_b | output | DW | Read port B data from the active bank |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register number written |
| wr_data | input | DW | Data written |
| sel_wr | input | 1 | Select register write strobe |
| sel_id | input | BW | Bank number written to the select register |
| irq_enter | input | 1 | Interrupt entry pulse |
| irq_exit | input | 1 | Interrupt exit pulse |
| cur_bank | output | BW | Number of the active bank |
| irq_active | output | 1 | High while the interrupt bank is active |

## Verification
Read data depends only on the current addresses and the active bank, so it is checked in the same cycle as the address is applied. Register writes, select writes and interrupt entry or exit show their effect exactly one rising edge later. The bench changes every input on the falling edge and samples one time step after a falling edge. A result is therefore always read after the edge that should produce it and before the next one. To confirm that nothing changes early, the bench checks the read value of a register being written, and cur_bank during a pending select write, before that edge as well.

// File: rtl/bankrf_pkg.sv
package bankrf_pkg;

  // true when a register number lies inside a bank of the given size
  function automatic logic addr_in_range(int unsigned addr, int unsigned depth);
    return addr < depth;
  endfunction

  // true when a bank number names a task bank (never the interrupt bank)
  function automatic logic task_id_ok(int unsigned id, int unsigned nbanks);
    return id < (nbanks - 1);
  endfunction

endpackage

// File: rtl/bankrf_ctrl.sv
module bankrf_ctrl
  import bankrf_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 5,
  parameter int unsigned BW        = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_wr,
  input  logic [BW-1:0] sel_id,
  input  logic          irq_enter,
  input  logic          irq_exit,
  output logic [BW-1:0] act_bank,
  output logic          irq_on
);
  localparam logic [BW-1:0] IRQ_ID = BW'(NUM_BANKS - 1);

  logic [BW-1:0] task_sel_q;
  logic          irq_q;

  // named events for the assertions
  logic sel_take, enter_ev, exit_ev;
  assign sel_take = sel_wr && !irq_q && task_id_ok(32'(sel_id), NUM_BANKS);
  assign enter_ev = irq_enter && !irq_q;
  assign exit_ev  = irq_exit && irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      task_sel_q <= '0;
      irq_q      <= 1'b0;
    end else begin
      if (sel_take) task_sel_q <= sel_id;
      if (enter_ev)     irq_q <= 1'b1;
      else if (exit_ev) irq_q <= 1'b0;
    end
  end

  assign act_bank = irq_q ? IRQ_ID : task_sel_q;
  assign irq_on   = irq_q;

  p_enter_r6: assert property (@(posedge clk) disable iff (!rst_n)
    enter_ev |=> (irq_on && act_bank == IRQ_ID));

  p_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    exit_ev |=> (!irq_on && act_bank == $past(task_sel_q)));

  p_bad_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_wr && !task_id_ok(32'(sel_id), NUM_BANKS)) |=> $stable(task_sel_q));

  p_irq_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && sel_wr) |=> $stable(task_sel_q));

  p_task_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_on |-> (act_bank < IRQ_ID));

endmodule

// File: rtl/bankrf_bank.sv
module bankrf_bank
  import bankrf_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned AW    = 5,
  parameter int unsigned DW    = 8,
  localparam int unsigned IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [DW-1:0] rdata_a,
  output logic [DW-1:0] rdata_b
);
  logic [DW-1:0] regs_q [DEPTH];
  logic          wr_hit;

  assign wr_hit = we && addr_in_range(32'(waddr), DEPTH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(DEPTH); i++) regs_q[i] <= '0;
    end else if (wr_hit) begin
      regs_q[waddr[IW-1:0]] <= wdata;
    end
  end

  assign rdata_a = addr_in_range(32'(raddr_a), DEPTH) ? regs_q[raddr_a[IW-1:0]] : '0;
  assign rdata_b = addr_in_range(32'(raddr_b), DEPTH) ? regs_q[raddr_b[IW-1:0]] : '0;

endmodule

// File: rtl/bankrf_top.sv
module bankrf_top
  import bankrf_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 5,
  parameter int unsigned REGS      = 32,
  parameter int unsigned IRQ_REGS  = 8,
  parameter int unsigned DW        = 8,
  localparam int unsigned AW       = $clog2(REGS),
  localparam int unsigned BW       = $clog2(NUM_BANKS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_addr_a,
  output logic [DW-1:0] rd_data_a,
  input  logic [AW-1:0] rd_addr_b,
  output logic [DW-1:0] rd_data_b,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          sel_wr,
  input  logic [BW-1:0] sel_id,
  input  logic          irq_enter,
  input  logic          irq_exit,
  output logic [BW-1:0] cur_bank,
  output logic          irq_active
);
  localparam int unsigned IRQ_ID = NUM_BANKS - 1;

  logic [BW-1:0]        act_bank;
  logic                 irq_on;
  logic [NUM_BANKS-1:0] bank_we;
  logic [DW-1:0]        bank_rd_a [NUM_BANKS];
  logic [DW-1:0]        bank_rd_b [NUM_BANKS];

  bankrf_ctrl #(.NUM_BANKS(NUM_BANKS), .BW(BW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_wr    (sel_wr),
    .sel_id    (sel_id),
    .irq_enter (irq_enter),
    .irq_exit  (irq_exit),
    .act_bank  (act_bank),
    .irq_on    (irq_on)
  );

  for (genvar g = 0; g < int'(NUM_BANKS); g++) begin : g_bank
    localparam int unsigned DEP = (32'(g) == IRQ_ID) ? IRQ_REGS : REGS;
    // write demultiplexer: only the active bank sees the strobe
    assign bank_we[g] = wr_en && (act_bank == BW'(g));
    bankrf_bank #(.DEPTH(DEP), .AW(AW), .DW(DW)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (bank_we[g]),
      .waddr   (wr_addr),
      .wdata   (wr_data),
      .raddr_a (rd_addr_a),
      .raddr_b (rd_addr_b),
      .rdata_a (bank_rd_a[g]),
      .rdata_b (bank_rd_b[g])
    );
  end

  // read multiplexer
  always_comb begin
    rd_data_a = '0;
    rd_data_b = '0;
    for (int b = 0; b < int'(NUM_BANKS); b++) begin
      if (act_bank == BW'(b)) begin
        rd_data_a = bank_rd_a[b];
        rd_data_b = bank_rd_b[b];
      end
    end
  end

  assign cur_bank   = act_bank;
  assign irq_active = irq_on;

  p_one_bank_we_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_we));

  p_we_routed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ($countones(bank_we) == 1));

  p_irq_oor_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_active && 32'(rd_addr_a) >= IRQ_REGS) |-> (rd_data_a == '0));

endmodule

// File: tb/tb_bankrf_top.sv
`timescale 1ns/100ps
module tb_bankrf_top;
  localparam int NB  = 5;
  localparam int NR  = 32;
  localparam int NI  = 8;
  localparam int IRQ = NB - 1;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [4:0] rd_addr_a, rd_addr_b, wr_addr;
  logic [7:0] rd_data_a, rd_data_b, wr_data;
  logic       wr_en, sel_wr, irq_enter, irq_exit, irq_active;
  logic [2:0] sel_id, cur_bank;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  int mdl [NB][NR];

  bankrf_top dut (
    .clk(clk), .rst_n(rst_n),
    .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
    .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sel_wr(sel_wr), .sel_id(sel_id),
    .irq_enter(irq_enter), .irq_exit(irq_exit),
    .cur_bank(cur_bank), .irq_active(irq_active)
  );

  always #2.5 clk = ~clk;

  function automatic int pat(int b, int r);
    return ((b * 53) + (r * 7) + 9) & 8'hFF;
  endfunction

  function automatic int expv(int b, int r);
    if (b == IRQ && r >= NI) return 0;
    return mdl[b][r];
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_write(int a, int v);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'(a); wr_data = 8'(v);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_sel(int id);
    @(negedge clk);
    sel_wr = 1'b1; sel_id = 3'(id);
    @(negedge clk);
    sel_wr = 1'b0;
  endtask

  task automatic pulse_enter();
    @(negedge clk); irq_enter = 1'b1;
    @(negedge clk); irq_enter = 1'b0;
  endtask

  task automatic pulse_exit();
    @(negedge clk); irq_exit = 1'b1;
    @(negedge clk); irq_exit = 1'b0;
  endtask

  // reads register r on port A and NR-1-r on port B of bank b
  task automatic read_pair(int b, int r, string req);
    rd_addr_a = 5'(r);
    rd_addr_b = 5'(NR - 1 - r);
    #1;
    check(int'(rd_data_a) == expv(b, r), req, int'(rd_data_a), expv(b, r));
    check(int'(rd_data_b) == expv(b, NR - 1 - r), req, int'(rd_data_b), expv(b, NR - 1 - r));
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < NB; b++) for (int r = 0; r < NR; r++) mdl[b][r] = 0;
    rst_n = 1'b0; wr_en = 0; wr_addr = 0; wr_data = 0; sel_wr = 0; sel_id = 0;
    irq_enter = 0; irq_exit = 0; rd_addr_a = 0; rd_addr_b = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check(cur_bank == 3'd0, "R1", int'(cur_bank), 0);
    check(irq_active == 1'b0, "R1", int'(irq_active), 0);

    // R1 all task banks clear, R4 select switching
    for (int b = 0; b < IRQ; b++) begin
      do_sel(b); #1;
      check(int'(cur_bank) == b, "R4", int'(cur_bank), b);
      for (int r = 0; r < NR; r++) read_pair(b, r, "R1");
    end
    pulse_enter(); #1;
    for (int r = 0; r < NR; r++) read_pair(IRQ, r, "R1");
    pulse_exit();

    // R4 select is not active until the edge
    @(negedge clk);
    sel_wr = 1'b1; sel_id = 3'd0; #1;
    check(int'(cur_bank) == IRQ - 1, "R4", int'(cur_bank), IRQ - 1);
    @(negedge clk); sel_wr = 1'b0; #1;
    check(cur_bank == 3'd0, "R4", int'(cur_bank), 0);

    // R10/R2 fill every task bank; check visibility right after each write
    for (int b = 0; b < IRQ; b++) begin
      do_sel(b);
      for (int r = 0; r < NR; r++) begin
        do_write(r, pat(b, r));
        mdl[b][r] = pat(b, r);
        read_pair(b, r, "R2");
      end
    end

    // R2 read during write returns old value before the edge
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'd4; wr_data = 8'hA5; rd_addr_a = 5'd4; #1;
    check(int'(rd_data_a) == mdl[IRQ-1][4], "R2", int'(rd_data_a), mdl[IRQ-1][4]);
    @(negedge clk); wr_en = 1'b0; mdl[IRQ-1][4] = 8'hA5; #1;
    check(int'(rd_data_a) == 8'hA5, "R2", int'(rd_data_a), 8'hA5);

    // R6 enter interrupt bank
    pulse_enter(); #1;
    check(int'(cur_bank) == IRQ, "R6", int'(cur_bank), IRQ);
    check(irq_active == 1'b1, "R6", int'(irq_active), 1);
    for (int r = 0; r < NI; r++) begin
      do_write(r, pat(IRQ, r));
      mdl[IRQ][r] = pat(IRQ, r);
    end
    // R9 writes above the interrupt bank size are dropped
    for (int r = NI; r < NR; r++) begin
      do_write(r, 8'hFF);
      read_pair(IRQ, r, "R9");
    end
    for (int r = 0; r < NI; r++) read_pair(IRQ, r, "R9");
    // R8 select write ignored while in interrupt
    do_sel(1); #1;
    check(int'(cur_bank) == IRQ, "R8", int'(cur_bank), IRQ);
    // R6 second entry has no effect
    pulse_enter(); #1;
    check(int'(cur_bank) == IRQ && irq_active, "R6", int'(cur_bank), IRQ);
    // R7 exit restores the preserved task bank (R8: not bank 1)
    pulse_exit(); #1;
    check(int'(cur_bank) == IRQ - 1, "R7", int'(cur_bank), IRQ - 1);
    check(irq_active == 1'b0, "R7", int'(irq_active), 0);
    pulse_exit(); #1;
    check(int'(cur_bank) == IRQ - 1 && !irq_active, "R7", int'(cur_bank), IRQ - 1);

    // R5 reserved and out-of-range select values
    for (int id = IRQ; id < 8; id++) begin
      do_sel(id); #1;
      check(int'(cur_bank) == IRQ - 1, "R5", int'(cur_bank), IRQ - 1);
      check(irq_active == 1'b0, "R5", int'(irq_active), 0);
    end

    // R3 every bank holds only its own writes
    for (int b = 0; b < IRQ; b++) begin
      do_sel(b);
      for (int r = 0; r < NR; r++) read_pair(b, r, "R3");
    end
    pulse_enter(); #1;
    for (int r = 0; r < NR; r++) read_pair(IRQ, r, "R3");
    pulse_exit(); #1;
    check(int'(cur_bank) == IRQ - 1, "R7", int'(cur_bank), IRQ - 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule